// File: doc/BRIEF.md
# Segmented prefetch bus interface

This block is the bus half of a 16-bit processor that addresses memory through segments. It holds four 16-bit segment bases and a 16-bit instruction pointer. A physical address is a base multiplied by sixteen plus a 16-bit offset, kept to 20 bits. While the execution side works, the block reads instruction bytes ahead of need from the code base and the instruction pointer into a short byte queue. The execution side pops those bytes in the order they were fetched.

Memory is reached through one synchronous byte port. The block raises a request with an address and holds it until the memory answers with ready. Jumps and calls use a flush input. A flush throws away the queued bytes, drops any prefetch still on the bus, loads a new instruction pointer and, if asked, a new code base. The execution side may also ask for one byte read or one byte write through any of the four segments. Such a request goes ahead of further prefetching once the bus cycle already running has ended.

Top module: `seg_prefetch_biu`

## Requirements
- R1: While reset is held, `mem_req` and `dat_done` are 0 and `q_empty` is 1. Reset clears the instruction pointer and all four segment bases, so the first fetch after reset reads address 00000h.
- R2: Every bus address equals (segment base × 16 + offset) mod 2^20. For example, base 3000h with offset 1234h gives 31234h, and base FFFFh with offset 0010h gives 00000h.
- R3: When `q_empty` is 0, `q_byte` shows the oldest queued byte. A pop removes it. Bytes leave the queue in the order they were fetched.
- R4: Prefetches read code base × 16 + instruction pointer. Each completed prefetch adds one to the instruction pointer, which wraps within 16 bits (FFFFh is followed by 0000h).
- R5: The queue holds 6 bytes. A prefetch starts only when fewer than 6 bytes are held, so without pops exactly 6 prefetches complete and `mem_req` then stays low. One pop allows exactly one more prefetch.
- R6: In the cycle after `flush`, `q_empty` is 1. Fetching then resumes at the new instruction pointer `flush_ip`. The code base is loaded from `flush_cs` only when `flush_cs_en` is 1; otherwise it keeps its value.
- R7: A flush during an unfinished prefetch withdraws the request, so `mem_req` is 0 in the next cycle. That byte never reaches the queue.
- R8: A pending data request is served before the next prefetch. A prefetch already on the bus finishes first, and then the data cycle is the very next bus cycle. For a read, `dat_rdata` holds the byte while `dat_done` pulses.
- R9: A data write drives `mem_we` = 1, with `mem_wdata` taken from `dat_wdata`, at the addressed location. `dat_done` pulses once the write is accepted.
- R10: The segment select code is 0 for code, 1 for data, 2 for stack and 3 for extra. It is used by `seg_wr_sel` and `dat_sel`. A pulse on `seg_wr_en` loads `seg_wr_val` into the selected base.
- R11: A pop while `q_empty` is 1 is ignored: the first byte fetched afterwards is still delivered.
- R12: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until `mem_ready` is seen. The only exception is a flush that cancels a prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load a segment base |
| seg_wr_sel | input | 2 | Segment to load (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_val | input | 16 | New segment base |
| flush | input | 1 | Discard queue and redirect fetching |
| flush_ip | input | 16 | New instruction pointer |
| flush_cs_en | input | 1 | Also load the code base with `flush_cs` |
| flush_cs | input | 16 | New code base |
| q_pop | input | 1 | Take the oldest queued byte |
| q_byte | output | 8 | Oldest queued byte |
| q_empty | output | 1 | Queue holds no byte |
| dat_req | input | 1 | Data access request, held until `dat_done` |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_sel | input | 2 | Segment used by the data access |
| dat_off | input | 16 | Offset of the data access |
| dat_wdata | input | 8 | Byte to write |
| dat_done | output | 1 | One-cycle pulse: data access finished |
| dat_rdata | output | 8 | Byte read, valid with `dat_done` |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 20 | Physical bus address |
| mem_wdata | output | 8 | Bus write byte |
| mem_rdata | input | 8 | Bus read byte, sampled with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current cycle |

## Verification
The embedded properties assume two things about the execution side. It keeps `dat_req` and its fields steady until it sees `dat_done`, and it drops the request in that same cycle. They also assume the memory answers with `mem_ready` only while `mem_req` is high. The bench's memory model raises ready only against a live request, after a programmable wait. Each data task holds its request fields until the done pulse and clears them on the cycle it sees that pulse. Flushes are issued either while no prefetch is completing or during a long memory wait, so a cancelled byte never counts as fetched.

// File: rtl/seg_biu_pkg.sv
package seg_biu_pkg;
   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_sel_e;

   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_FETCH = 2'd1,
      BUS_DATA  = 2'd2
   } bus_state_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] phys
);
   logic [ADDR_W-1:0] base;

   initial begin
      if (SEG_W + SHIFT < ADDR_W)
         $fatal(1, "seg_addr_gen: shifted base narrower than address");
      if (OFF_W > ADDR_W)
         $fatal(1, "seg_addr_gen: offset wider than address");
   end

   generate
      if (SHIFT == 0) begin : g_flat
         assign base = ADDR_W'(seg);
      end else begin : g_shifted
         assign base = ADDR_W'({seg, {SHIFT{1'b0}}});
      end
   endgenerate

   // sum is truncated to ADDR_W, wrapping modulo 2^ADDR_W
   assign phys = base + ADDR_W'(off);
endmodule

// File: rtl/pf_byte_queue.sv
module pf_byte_queue #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0]  count;
   logic              do_push, do_pop;

   initial begin
      if (DEPTH < 2) $fatal(1, "pf_byte_queue: DEPTH must be at least 2");
   end

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = slots[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clear) slots[wr_ptr] <= push_data;
   end

   // R5: the sequencer never completes a fetch into a full queue
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R11: an unmatched pop on an empty queue leaves it empty
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clear) |=> empty);
endmodule

// File: rtl/biu_bus_seq.sv
module biu_bus_seq
   import seg_biu_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              room,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              dat_req,
   input  logic              dat_we,
   input  logic [ADDR_W-1:0] dat_addr,
   input  logic [DATA_W-1:0] dat_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              dat_done,
   output logic [DATA_W-1:0] dat_rdata
);
   bus_state_e state;

   assign mem_req   = (state != BUS_IDLE);
   assign push      = (state == BUS_FETCH) && mem_ready && !flush;
   assign push_data = mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= BUS_IDLE;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         dat_done  <= 1'b0;
         dat_rdata <= '0;
      end else begin
         dat_done <= 1'b0;
         unique case (state)
            BUS_IDLE: begin
               if (!flush) begin
                  if (dat_req && !dat_done) begin
                     state     <= BUS_DATA;
                     mem_addr  <= dat_addr;
                     mem_we    <= dat_we;
                     mem_wdata <= dat_wdata;
                  end else if (room) begin
                     state    <= BUS_FETCH;
                     mem_addr <= fetch_addr;
                     mem_we   <= 1'b0;
                  end
               end
            end
            BUS_FETCH: begin
               if (flush || mem_ready) state <= BUS_IDLE;
            end
            BUS_DATA: begin
               if (mem_ready) begin
                  state    <= BUS_IDLE;
                  dat_done <= 1'b1;
                  if (!mem_we) dat_rdata <= mem_rdata;
               end
            end
            default: state <= BUS_IDLE;
         endcase
      end
   end

   // R12
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready && !flush) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R8
   data_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_done |-> $past(mem_req && mem_ready && state == BUS_DATA));
endmodule

// File: rtl/seg_prefetch_biu.sv
module seg_prefetch_biu
   import seg_biu_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 8,
   parameter int Q_DEPTH   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_wr_en,
   input  logic [1:0]        seg_wr_sel,
   input  logic [SEG_W-1:0]  seg_wr_val,
   input  logic              flush,
   input  logic [OFF_W-1:0]  flush_ip,
   input  logic              flush_cs_en,
   input  logic [SEG_W-1:0]  flush_cs,
   input  logic              q_pop,
   output logic [DATA_W-1:0] q_byte,
   output logic              q_empty,
   input  logic              dat_req,
   input  logic              dat_we,
   input  logic [1:0]        dat_sel,
   input  logic [OFF_W-1:0]  dat_off,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic              dat_done,
   output logic [DATA_W-1:0] dat_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int NUM_SEG = 4;
   localparam int SEL_W   = $clog2(NUM_SEG);

   logic [SEG_W-1:0]  seg_q [NUM_SEG];
   logic [OFF_W-1:0]  ip_q;
   logic [ADDR_W-1:0] fetch_addr, dat_addr;
   logic              q_full, push;
   logic [DATA_W-1:0] push_data;

   // segment bases; the code base also takes the flush load
   generate
      for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
         logic [SEG_W-1:0] base_r;
         logic             wr_hit;
         assign wr_hit = seg_wr_en && (seg_wr_sel == SEL_W'(g));
         if (g == int'(SEG_CODE)) begin : g_code
            always_ff @(posedge clk) begin
               if (!rst_n)                    base_r <= '0;
               else if (flush && flush_cs_en) base_r <= flush_cs;
               else if (wr_hit)               base_r <= seg_wr_val;
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)      base_r <= '0;
               else if (wr_hit) base_r <= seg_wr_val;
            end
         end
         assign seg_q[g] = base_r;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     ip_q <= '0;
      else if (flush) ip_q <= flush_ip;
      else if (push)  ip_q <= ip_q + 1'b1;
   end

   seg_addr_gen #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) i_fetch_agen (
      .seg(seg_q[SEG_CODE]), .off(ip_q), .phys(fetch_addr)
   );

   seg_addr_gen #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) i_data_agen (
      .seg(seg_q[dat_sel]), .off(dat_off), .phys(dat_addr)
   );

   pf_byte_queue #(
      .DATA_W(DATA_W), .DEPTH(Q_DEPTH)
   ) i_queue (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .push(push), .push_data(push_data),
      .pop(q_pop), .head(q_byte), .empty(q_empty), .full(q_full)
   );

   biu_bus_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .room(!q_full),
      .fetch_addr(fetch_addr),
      .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr),
      .dat_wdata(dat_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata),
      .push(push), .push_data(push_data),
      .dat_done(dat_done), .dat_rdata(dat_rdata)
   );

   // R6
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> q_empty);
endmodule

// File: tb/test_seg_prefetch_biu.sv
module test_seg_prefetch_biu;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        seg_wr_en = 0;
   logic [1:0]  seg_wr_sel = 0;
   logic [15:0] seg_wr_val = 0;
   logic        flush = 0;
   logic [15:0] flush_ip = 0;
   logic        flush_cs_en = 0;
   logic [15:0] flush_cs = 0;
   logic        q_pop = 0;
   logic [7:0]  q_byte;
   logic        q_empty;
   logic        dat_req = 0, dat_we = 0;
   logic [1:0]  dat_sel = 0;
   logic [15:0] dat_off = 0;
   logic [7:0]  dat_wdata = 0;
   logic        dat_done;
   logic [7:0]  dat_rdata;
   logic        mem_req, mem_we;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 0;
   logic        mem_ready = 0;

   int n_run = 0, n_fail = 0;
   int mem_wait = 0, wctr = 0, hs_cnt = 0, fetch_cnt = 0;
   logic [19:0] last_hs_addr = 0;
   logic        last_hs_we = 0;
   logic [7:0]  last_hs_wdata = 0;

   always #2 clk = ~clk;

   seg_prefetch_biu i_seg_prefetch_biu (
      .clk(clk), .rst_n(rst_n),
      .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_val(seg_wr_val),
      .flush(flush), .flush_ip(flush_ip), .flush_cs_en(flush_cs_en),
      .flush_cs(flush_cs),
      .q_pop(q_pop), .q_byte(q_byte), .q_empty(q_empty),
      .dat_req(dat_req), .dat_we(dat_we), .dat_sel(dat_sel),
      .dat_off(dat_off), .dat_wdata(dat_wdata),
      .dat_done(dat_done), .dat_rdata(dat_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   function automatic logic [7:0] memfn(logic [19:0] a);
      return (a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h0}) + 8'h3C;
   endfunction

   // memory model: ready after mem_wait idle cycles of a live request
   always @(negedge clk) begin
      mem_rdata = memfn(mem_addr);
      if (!rst_n || !mem_req) begin
         mem_ready = 1'b0;
         wctr      = 0;
      end else if (wctr >= mem_wait) begin
         mem_ready     = 1'b1;
         hs_cnt++;
         last_hs_addr  = mem_addr;
         last_hs_we    = mem_we;
         last_hs_wdata = mem_wdata;
         if (!mem_we) fetch_cnt++;
      end else begin
         mem_ready = 1'b0;
         wctr++;
      end
   end

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic do_flush(logic [15:0] ip, bit cs_en, logic [15:0] cs);
      flush = 1; flush_ip = ip; flush_cs_en = cs_en; flush_cs = cs;
      @(negedge clk);
      flush = 0; flush_cs_en = 0;
   endtask

   task automatic pop_byte(output logic [7:0] b);
      int guard = 0;
      while (q_empty && guard < 300) begin
         @(negedge clk);
         guard++;
      end
      b = q_byte;
      q_pop = 1;
      @(negedge clk);
      q_pop = 0;
   endtask

   task automatic seg_write(logic [1:0] sel, logic [15:0] val);
      seg_wr_en = 1; seg_wr_sel = sel; seg_wr_val = val;
      @(negedge clk);
      seg_wr_en = 0;
   endtask

   task automatic data_access(logic [1:0] sel, logic [15:0] off, bit we,
                              logic [7:0] wd, output logic [7:0] rd);
      int guard = 0;
      dat_req = 1; dat_sel = sel; dat_off = off; dat_we = we; dat_wdata = wd;
      do begin
         @(negedge clk);
         guard++;
      end while (!dat_done && guard < 300);
      rd = dat_rdata;
      dat_req = 0; dat_we = 0;
   endtask

   task automatic test_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(mem_req == 0 && dat_done == 0, "R1 idle bus in reset", {30'd0, mem_req, dat_done}, 0);
      chk(q_empty == 1, "R1 queue empty in reset", q_empty, 1);
      rst_n = 1;
      @(negedge clk);
      chk(mem_req == 1 && mem_addr == 20'h00000, "R1 first fetch address", mem_addr, 0);
   endtask

   task automatic test_stream();
      logic [7:0] b;
      do_flush(16'h1234, 1, 16'h3000);
      chk(q_empty == 1, "R6 empty after flush", q_empty, 1);
      @(negedge clk);
      chk(mem_req == 1 && mem_addr == 20'h31234, "R2 fetch address 3000:1234", mem_addr, 20'h31234);
      for (int i = 0; i < 8; i++) begin
         pop_byte(b);
         chk(b == memfn(20'h31234 + 20'(i)), "R3 R4 in-order prefetch byte", b, memfn(20'h31234 + 20'(i)));
      end
   endtask

   task automatic test_wrap();
      logic [7:0] b;
      do_flush(16'h0010, 1, 16'hFFFF);
      @(negedge clk);
      chk(mem_addr == 20'h00000, "R2 address wraps at 2^20", mem_addr, 0);
      do_flush(16'hFFFF, 1, 16'h1000);
      pop_byte(b);
      chk(b == memfn(20'h1FFFF), "R4 byte at IP FFFF", b, memfn(20'h1FFFF));
      pop_byte(b);
      chk(b == memfn(20'h10000), "R4 IP wraps to 0000", b, memfn(20'h10000));
   endtask

   task automatic test_full();
      logic [7:0] b;
      do_flush(16'h0100, 1, 16'h0200);
      fetch_cnt = 0;
      repeat (60) @(negedge clk);
      chk(fetch_cnt == 6, "R5 six prefetches fill queue", fetch_cnt, 6);
      chk(mem_req == 0, "R5 no fetch when full", mem_req, 0);
      pop_byte(b);
      chk(b == memfn(20'h02100), "R3 head of full queue", b, memfn(20'h02100));
      repeat (10) @(negedge clk);
      chk(fetch_cnt == 7, "R5 one pop frees one fetch", fetch_cnt, 7);
   endtask

   task automatic test_pop_empty();
      logic [7:0] b;
      do_flush(16'h0000, 1, 16'h0400);
      q_pop = 1;
      @(negedge clk);
      q_pop = 0;
      chk(q_empty == 1, "R11 still empty after ignored pop", q_empty, 1);
      pop_byte(b);
      chk(b == memfn(20'h04000), "R11 first byte survives ignored pop", b, memfn(20'h04000));
   endtask

   task automatic test_cancel();
      logic [7:0] b;
      mem_wait = 10;
      do_flush(16'h0000, 1, 16'h0500);
      @(negedge clk);
      chk(mem_req == 1 && mem_addr == 20'h05000, "R12 fetch raised", mem_addr, 20'h05000);
      repeat (2) @(negedge clk);
      chk(mem_req == 1 && mem_addr == 20'h05000, "R12 request held while waiting", mem_addr, 20'h05000);
      do_flush(16'h0080, 0, 16'hABCD);
      chk(mem_req == 0, "R7 request withdrawn by flush", mem_req, 0);
      mem_wait = 0;
      pop_byte(b);
      chk(b == memfn(20'h05080), "R7 R6 cancelled byte dropped, code base kept", b, memfn(20'h05080));
   endtask

   task automatic test_data();
      logic [7:0] rd;
      seg_write(2'd1, 16'h2042);
      data_access(2'd1, 16'h0500, 0, 8'h00, rd);
      chk(last_hs_addr == 20'h20920 && last_hs_we == 0, "R10 R2 data read address", last_hs_addr, 20'h20920);
      chk(rd == memfn(20'h20920), "R8 read data returned", rd, memfn(20'h20920));
      seg_write(2'd3, 16'h1111);
      data_access(2'd3, 16'h0022, 1, 8'hA5, rd);
      chk(last_hs_we == 1 && last_hs_addr == 20'h11132, "R9 write address", last_hs_addr, 20'h11132);
      chk(last_hs_wdata == 8'hA5, "R9 write data", last_hs_wdata, 8'hA5);
   endtask

   task automatic test_priority();
      logic [7:0] rd;
      int n0;
      seg_write(2'd2, 16'h7000);
      mem_wait = 3;
      do_flush(16'h0000, 1, 16'h0600);
      @(negedge clk);
      chk(mem_req == 1 && mem_we == 0, "R8 prefetch in progress", mem_req, 1);
      n0 = hs_cnt;
      data_access(2'd2, 16'h0010, 0, 8'h00, rd);
      chk(hs_cnt == n0 + 2, "R8 data next after current fetch", hs_cnt, n0 + 2);
      chk(last_hs_addr == 20'h70010, "R8 R10 stack data address", last_hs_addr, 20'h70010);
      chk(rd == memfn(20'h70010), "R8 stack read data", rd, memfn(20'h70010));
      mem_wait = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0;
      @(negedge clk);
      test_reset();
      test_stream();
      test_wrap();
      test_full();
      test_pop_empty();
      test_cancel();
      test_data();
      test_priority();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule